// File: doc/BRIEF.md
# Coded Output Post-Divider

This block takes the VCO clock of a frequency synthesizer and divides it down to the output frequency. A 2-bit ratio code picks the division, and the mapping is deliberately not monotonic: two codes give halving and quartering, one gives division by eight, and the last passes the VCO clock straight through. A slow-mode input multiplies the chosen division by a further sixteen, so the output falls to one sixteenth of its normal rate. An active-high output enable gates the result. When the enable is low the output is held low.

Changes to the code, to slow mode and to the enable are never applied mid-pulse. The block registers each request and adopts it only at the end of the current low phase, which is where the next high phase would otherwise start. The old waveform therefore always completes a whole period, and the new one starts with a whole high phase, so no runt pulse can appear. Every even ratio gives an exact 50% duty cycle. All state runs on the rising edge of the VCO clock.

Top module: `coded_post_div`

## Requirements
- R1: With ratio code 2'b00 and slow mode off, the output has a period of 2 input cycles, with 1 cycle high and 1 cycle low.
- R2: With ratio code 2'b01 and slow mode off, the output has a period of 4 input cycles, with 2 high and 2 low.
- R3: With ratio code 2'b10 and slow mode off, the output has a period of 8 input cycles, with 4 high and 4 low.
- R4: With ratio code 2'b11 and slow mode off, the output follows the input clock: it is high during the high half of each input cycle and low during the low half.
- R5: With slow mode on, each code's division is multiplied by 16 (code 11 gives 16, 00 gives 32, 01 gives 64, 10 gives 128), always with equal high and low phases. The internal count never exceeds the active ratio minus one.
- R6: A change of ratio code or of slow mode takes effect only where a low phase of the current ratio ends. Across the change, every complete high or low interval equals half the period of either the old ratio or the new one.
- R7: While the output enable is low, the output stays low. Disabling and enabling take effect only at the end of a low phase, so the last pulse before disabling and the first pulse after enabling both have full length.
- R8: While reset is asserted, the output is low and the counter is cleared. After release, the output stays low for the first input cycle, and the requested setting is adopted at the first low-phase boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | VCO clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 2 | Ratio code: 00 gives /2, 01 gives /4, 10 gives /8, 11 gives /1 |
| slow_mode | input | 1 | When high, multiplies the division by 16 |
| out_en | input | 1 | Active-high output enable; when low, the output is held low |
| clk_out | output | 1 | Divided output clock |

## Verification
The hardest situation to reach from the ports is a request that arrives at an arbitrary point inside a long high or low phase, especially when entering or leaving slow mode. In that case the block must wait up to 128 cycles before it switches. The bench reaches this by forking a run-length monitor alongside a stimulus branch. The stimulus branch applies the new code or slow setting after a swept offset of cycles, and the monitor checks that every complete interval matches half of either the old period or the new one. Disabling and re-enabling are driven the same way, partway through a pulse train.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_HALF    = 2'b00,
    CODE_QUARTER = 2'b01,
    CODE_EIGHTH  = 2'b10,
    CODE_THRU    = 2'b11
  } ratio_code_e;

  // log2 of the base division selected by a ratio code
  function automatic logic [1:0] code_to_shift(input logic [CODE_W-1:0] code);
    case (ratio_code_e'(code))
      CODE_HALF:    return 2'd1;
      CODE_QUARTER: return 2'd2;
      CODE_EIGHTH:  return 2'd3;
      default:      return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cpd_ratio_decode.sv
module cpd_ratio_decode
  import cpd_pkg::*;
#(
  parameter int SLOW_SHIFT = 4,
  parameter int SW         = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic              slow,
  output logic [SW-1:0]     req_sh
);
  logic [SW-1:0] base_sh;
  logic [SW-1:0] extra_sh;

  always_comb begin
    base_sh  = SW'(code_to_shift(code));
    extra_sh = slow ? SW'(SLOW_SHIFT) : '0;
    req_sh   = base_sh + extra_sh;
  end
endmodule

// File: rtl/cpd_phase_gen.sv
module cpd_phase_gen #(
  parameter int SW     = 3,
  parameter int CW     = 7,
  parameter int RST_SH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] req_sh,
  input  logic          req_en,
  output logic [SW-1:0] act_sh,
  output logic [CW-1:0] cnt,
  output logic          div_q,
  output logic          en_q
);
  localparam int PW = CW + 1;

  logic [PW-1:0] period;
  logic [PW-1:0] half_w;
  logic [PW-1:0] cnt_nx;
  logic          at_bound;

  always_comb begin
    period   = PW'(1) << act_sh;
    half_w   = period >> 1;
    cnt_nx   = {1'b0, cnt} + PW'(1);
    // the final count of a period is always inside the low phase
    at_bound = ({1'b0, cnt} == (period - PW'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sh <= SW'(RST_SH);
      cnt    <= '0;
      div_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (at_bound) begin
      act_sh <= req_sh;
      en_q   <= req_en;
      cnt    <= '0;
      div_q  <= (req_sh != '0);
    end else begin
      cnt    <= cnt_nx[CW-1:0];
      div_q  <= (cnt_nx < half_w);
    end
  end
endmodule

// File: rtl/cpd_out_stage.sv
module cpd_out_stage #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic [SW-1:0] act_sh,
  input  logic          div_q,
  input  logic          en_q,
  output logic          clk_out
);
  logic thru;

  always_comb begin
    thru    = (act_sh == '0);
    clk_out = en_q & (thru ? clk : div_q);
  end
endmodule

// File: rtl/coded_post_div.sv
module coded_post_div #(
  parameter int SLOW_SHIFT = 4
) (
  input  logic       clk_vco,
  input  logic       rst_n,
  input  logic [1:0] ratio_code,
  input  logic       slow_mode,
  input  logic       out_en,
  output logic       clk_out
);
  localparam int MAX_SH = 3 + SLOW_SHIFT;
  localparam int SW     = $clog2(MAX_SH + 1);
  localparam int CW     = MAX_SH;

  logic [SW-1:0] req_sh;
  logic [SW-1:0] act_sh;
  logic [CW-1:0] cnt;
  logic          div_q;
  logic          en_q;

  cpd_ratio_decode #(.SLOW_SHIFT(SLOW_SHIFT), .SW(SW)) u_dec (
    .code   (ratio_code),
    .slow   (slow_mode),
    .req_sh (req_sh)
  );

  cpd_phase_gen #(.SW(SW), .CW(CW), .RST_SH(1)) u_gen (
    .clk    (clk_vco),
    .rst_n  (rst_n),
    .req_sh (req_sh),
    .req_en (out_en),
    .act_sh (act_sh),
    .cnt    (cnt),
    .div_q  (div_q),
    .en_q   (en_q)
  );

  cpd_out_stage #(.SW(SW)) u_out (
    .clk     (clk_vco),
    .act_sh  (act_sh),
    .div_q   (div_q),
    .en_q    (en_q),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int SW = 3,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] act_sh,
  input logic [CW-1:0] cnt,
  input logic          div_q,
  input logic          en_q
);
  logic [CW:0] period;
  logic [CW:0] half_w;

  always_comb begin
    period = (CW+1)'(1) << act_sh;
    half_w = period >> 1;
  end

  assert_reset_low_R8: assert property (@(posedge clk)
    !rst_n |-> (!div_q && !en_q && cnt == '0));

  assert_ratio_at_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sh != $past(act_sh)) |-> !$past(div_q));

  assert_enable_at_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> !$past(div_q));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < period));

  assert_even_duty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && act_sh == $past(act_sh)) |-> ({1'b0, cnt} == half_w));

  assert_thru_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sh == '0) |-> !div_q);
endmodule

bind coded_post_div cpd_checker #(.SW(SW), .CW(CW)) u_chk (
  .clk    (clk_vco),
  .rst_n  (rst_n),
  .act_sh (act_sh),
  .cnt    (cnt),
  .div_q  (div_q),
  .en_q   (en_q)
);

// File: tb/coded_post_div_tb.sv
module coded_post_div_tb;
  localparam int CLK_PERIOD = 8;

  logic       clk_vco = 1'b0;
  logic       rst_n;
  logic [1:0] ratio_code;
  logic       slow_mode;
  logic       out_en;
  logic       clk_out;

  int n_run  = 0;
  int n_fail = 0;

  coded_post_div u_dut (
    .clk_vco    (clk_vco),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .slow_mode  (slow_mode),
    .out_en     (out_en),
    .clk_out    (clk_out)
  );

  always #(CLK_PERIOD/2) clk_vco = ~clk_vco;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  // one input cycle: sample in the high half, then in the low half
  task automatic tick(output logic hi, output logic lo);
    @(posedge clk_vco); #2 hi = clk_out;
    @(negedge clk_vco); #2 lo = clk_out;
  endtask

  function automatic int ratio_of(input int code, input bit slow);
    int sh = (code == 3) ? 0 : code + 1;
    if (slow) sh += 4;
    return 1 << sh;
  endfunction

  task automatic steady_check(input int code, input bit slow, input string req);
    logic hi, lo, prev;
    int r = ratio_of(code, slow);
    int bad = 0, badk = 0;
    bit found = 0;
    ratio_code = 2'(code); slow_mode = slow; out_en = 1'b1;
    repeat (300) tick(hi, lo);
    if (r == 1) begin
      for (int k = 0; k < 8; k++) begin
        tick(hi, lo);
        if (hi !== 1'b1 || lo !== 1'b0) begin bad++; badk = k; end
      end
      chk(bad == 0, req, badk, -1);
    end else begin
      prev = hi;
      for (int k = 0; k < 2*r && !found; k++) begin
        tick(hi, lo);
        if (prev === 1'b0 && hi === 1'b1) found = 1;
        prev = hi;
      end
      chk(found, req, 0, 1);
      for (int k = 1; k < 2*r; k++) begin
        tick(hi, lo);
        if (hi !== logic'((k % r) < r/2)) begin bad++; badk = k; end
      end
      chk(bad == 0, req, badk, -1);
    end
  endtask

  // every complete run of equal samples must be ha or hb cycles long
  task automatic run_check(input int ncyc, input int ha, input int hb, input string req);
    logic prev, hi, lo;
    int run = 1, nr = 0, bad = 0, badlen = ha;
    tick(prev, lo);
    for (int i = 1; i < ncyc; i++) begin
      tick(hi, lo);
      if (hi === prev) run++;
      else begin
        if (nr > 0 && run != ha && run != hb) begin bad++; badlen = run; end
        nr++; run = 1; prev = hi;
      end
    end
    chk(bad == 0 && nr >= 2, req, badlen, ha);
  endtask

  task automatic switch_check(input int ca, input bit sa, input int cb, input bit sb,
                              input int off, input string req);
    logic hi, lo;
    ratio_code = 2'(ca); slow_mode = sa; out_en = 1'b1;
    repeat (300) tick(hi, lo);
    fork
      run_check(700, ratio_of(ca, sa)/2, ratio_of(cb, sb)/2, req);
      begin
        repeat (off + 3) @(posedge clk_vco);
        #3 ratio_code = 2'(cb); slow_mode = sb;
      end
    join
  endtask

  initial begin
    logic hi, lo;
    int bad;
    rst_n = 1'b0; ratio_code = 2'b00; slow_mode = 1'b0; out_en = 1'b1;
    // R8: low during reset
    for (int k = 0; k < 3; k++) begin
      tick(hi, lo);
      chk(hi === 1'b0 && lo === 1'b0, "R8", int'(hi), 0);
    end
    rst_n = 1'b1;
    tick(hi, lo);
    chk(hi === 1'b0, "R8", int'(hi), 0);

    steady_check(0, 0, "R1");
    steady_check(1, 0, "R2");
    steady_check(2, 0, "R3");
    steady_check(3, 0, "R4");
    steady_check(3, 1, "R5");
    steady_check(0, 1, "R5");
    steady_check(1, 1, "R5");
    steady_check(2, 1, "R5");

    // R6: ratio code changes at swept offsets
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (a != b)
          for (int off = 0; off < 8; off += 3)
            switch_check(a, 0, b, 0, off, "R6");
    // R6: slow mode toggled in both directions
    for (int c = 0; c < 3; c++)
      for (int off = 0; off < 4; off += 3) begin
        switch_check(c, 0, c, 1, off, "R6");
        switch_check(c, 1, c, 0, off + 17, "R6");
      end

    // R7: disable mid-train, no short pulse, then held low
    ratio_code = 2'b01; slow_mode = 1'b0; out_en = 1'b1;
    repeat (300) tick(hi, lo);
    fork
      run_check(60, 2, 2, "R7");
      begin repeat (31) @(posedge clk_vco); #3 out_en = 1'b0; end
    join
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      tick(hi, lo);
      if (hi !== 1'b0 || lo !== 1'b0) bad++;
    end
    chk(bad == 0, "R7", bad, 0);
    fork
      run_check(60, 2, 2, "R7");
      begin repeat (5) @(posedge clk_vco); #3 out_en = 1'b1; end
    join
    // R7: disabled pass-through stays low
    ratio_code = 2'b11; out_en = 1'b0;
    repeat (20) tick(hi, lo);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      tick(hi, lo);
      if (hi !== 1'b0 || lo !== 1'b0) bad++;
    end
    chk(bad == 0, "R7", bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule